// File: doc/BRIEF.md
# Serial Number Pool Allocator

This block keeps a pool of 8-bit serial numbers that processing threads borrow and hand back. Each slot holds a fixed serial value and a used flag. The values come from a constant table that is not a simple count. A requester raises an allocate strobe. One cycle later the block answers with the serial value of the lowest-numbered free slot, which is now marked used. If no slot is free, it answers with a failure pulse. A releaser returns a serial number by value. The block finds the slot that holds that value and frees it.

The number of live slots is taken from a configuration input while reset is held. A setting outside the legal range falls back to a default. Slots at or above the live size take no part in allocation or release. A free-slot count output always shows the current pool state.

Top module: `snum_pool`

## Requirements
- R1: While reset is asserted every slot is cleared to free. After reset, resp_valid and resp_fail are low and free_cnt equals the selected pool size.
- R2: The pool size is captured from cfg_size while rst is high. A value from 28 to 46 inclusive is used as given. Any other value selects 28. The size then holds until the next reset.
- R3: Slot i holds a fixed serial value. Let k = i/2, and let bit 0 of the value be i mod 2. For k from 0 to 6 the value is 0x04+8k. For k from 7 to 13 it is 0x88+16(k-7). For k from 14 to 21 it is 0x08+16(k-14). For k = 22 it is 0x80.
- R4: An allocate request that finds a free slot takes the lowest-indexed free live slot and marks it used. In the next cycle the block raises resp_valid for one cycle, puts that slot's value on resp_val and lowers free_cnt by one.
- R5: An allocate request that finds no free live slot raises resp_fail for one cycle in the next cycle. resp_val is 0 and the pool is unchanged.
- R6: A release whose value matches a live slot marks that slot free. free_cnt rises by one if the slot was used.
- R7: A release whose value matches no live slot is ignored. This covers values outside the table and values held by slots at or above the pool size. free_cnt is unchanged.
- R8: Releasing a value whose slot is already free leaves free_cnt unchanged.
- R9: When allocate and release occur in the same cycle, the release is applied first. An allocation on a full pool therefore succeeds and returns the released value when that slot is the lowest free one.
- R10: Slots at or above the pool size are never handed out. Once all live slots are used, further requests fail.
- R11: free_cnt always equals the number of free live slots and never exceeds the pool size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; size captured while high |
| cfg_size | input | 6 | Requested pool size, sampled during reset |
| alloc_req | input | 1 | Allocate strobe, one request per cycle |
| rel_req | input | 1 | Release strobe |
| rel_val | input | 8 | Serial value being returned |
| resp_valid | output | 1 | Allocation succeeded (one cycle after request) |
| resp_fail | output | 1 | Allocation failed, pool empty |
| resp_val | output | 8 | Serial value granted, 0 when not valid |
| free_cnt | output | 6 | Number of free live slots |

## Verification
The bench drives the size selection with values just below the lower limit, at the limit, at the table end and well past it. A design with a wrong bound would show the wrong free count right after reset. It drains pools of 28 and 46 slots and compares every value returned against the table rule. A slip in scan order or in the table would return a wrong value, and a size mask that leaks would return a 29th value instead of failing. Releases of values held by slots above the size, of values absent from the table and of slots that are already free must leave the count alone. A design that matched by index or forgot the mask would change it. An allocate and a release in the same cycle on a full pool must succeed, which a design that applied the allocation first would fail.

// File: rtl/snum_pool_pkg.sv
package snum_pool_pkg;

   // Number of serial values defined by the fixed table
   localparam int unsigned TABLE_LEN = 46;
   localparam int unsigned SER_W     = 8;

   // Serial value held by slot idx; slots come in adjacent odd/even pairs
   function automatic logic [SER_W-1:0] serial_of(input int unsigned idx);
      int unsigned k;
      logic [SER_W-1:0] base;
      k = idx >> 1;
      if (k < 7)
         base = SER_W'(8'h04 + 8 * k);
      else if (k < 14)
         base = SER_W'(8'h88 + 16 * (k - 7));
      else if (k < 22)
         base = SER_W'(8'h08 + 16 * (k - 14));
      else
         base = 8'h80;
      return base | SER_W'(idx & 1);
   endfunction

endpackage

// File: rtl/snum_size_sel.sv
module snum_size_sel #(
   parameter int unsigned NUM_ENTRIES = 46,
   parameter int unsigned MIN_ENTRIES = 28,
   parameter int unsigned DEF_ENTRIES = 28,
   localparam int unsigned CNT_W = $clog2(NUM_ENTRIES + 1)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [CNT_W-1:0]       cfg_size,
   output logic [CNT_W-1:0]       size_q,
   output logic [NUM_ENTRIES-1:0] active
);

   generate
      if (MIN_ENTRIES < 1 || MIN_ENTRIES > NUM_ENTRIES) begin : g_bad_min
         $error("snum_size_sel: MIN_ENTRIES out of range");
      end
      if (DEF_ENTRIES < MIN_ENTRIES || DEF_ENTRIES > NUM_ENTRIES) begin : g_bad_def
         $error("snum_size_sel: DEF_ENTRIES out of range");
      end
   endgenerate

   logic cfg_ok;
   assign cfg_ok = (cfg_size >= CNT_W'(MIN_ENTRIES)) && (cfg_size <= CNT_W'(NUM_ENTRIES));

   always_ff @(posedge clk) begin
      if (rst)
         size_q <= cfg_ok ? cfg_size : CNT_W'(DEF_ENTRIES);
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_act
         assign active[gi] = (size_q > CNT_W'(gi));
      end
   endgenerate

   // R2
   size_range_chk: assert property (@(posedge clk) disable iff (rst)
      (size_q >= CNT_W'(MIN_ENTRIES)) && (size_q <= CNT_W'(NUM_ENTRIES)));

   // R2
   size_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(size_q));

endmodule

// File: rtl/snum_rel_match.sv
module snum_rel_match
   import snum_pool_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 46,
   parameter int unsigned VAL_W       = 8
) (
   input  logic                   rel_req,
   input  logic [VAL_W-1:0]       rel_val,
   input  logic [NUM_ENTRIES-1:0] active,
   output logic [NUM_ENTRIES-1:0] hit
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_cmp
         localparam logic [VAL_W-1:0] SLOT_VAL = VAL_W'(serial_of(gi));
         assign hit[gi] = rel_req && active[gi] && (rel_val == SLOT_VAL);
      end
   endgenerate

endmodule

// File: rtl/snum_pick.sv
module snum_pick
   import snum_pool_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 46,
   parameter int unsigned VAL_W       = 8
) (
   input  logic [NUM_ENTRIES-1:0] free_vec,
   output logic                   found,
   output logic [NUM_ENTRIES-1:0] grant,
   output logic [VAL_W-1:0]       value
);

   // Lowest index wins
   always_comb begin
      grant = '0;
      found = 1'b0;
      for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
         if (free_vec[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   logic [VAL_W-1:0] part [NUM_ENTRIES+1];
   assign part[0] = '0;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_val
         localparam logic [VAL_W-1:0] SLOT_VAL = VAL_W'(serial_of(gi));
         assign part[gi+1] = part[gi] | (grant[gi] ? SLOT_VAL : '0);
      end
   endgenerate

   assign value = part[NUM_ENTRIES];

endmodule

// File: rtl/snum_popcount.sv
module snum_popcount #(
   parameter int unsigned N = 46,
   localparam int unsigned W = $clog2(N + 1)
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] cnt
);

   always_comb begin
      cnt = '0;
      for (int i = 0; i < int'(N); i++)
         cnt = cnt + W'(vec[i]);
   end

endmodule

// File: rtl/snum_pool.sv
module snum_pool
   import snum_pool_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 46,
   parameter int unsigned MIN_ENTRIES = 28,
   parameter int unsigned DEF_ENTRIES = 28,
   parameter int unsigned VAL_W       = 8,
   localparam int unsigned CNT_W = $clog2(NUM_ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cfg_size,
   input  logic             alloc_req,
   input  logic             rel_req,
   input  logic [VAL_W-1:0] rel_val,
   output logic             resp_valid,
   output logic             resp_fail,
   output logic [VAL_W-1:0] resp_val,
   output logic [CNT_W-1:0] free_cnt
);

   generate
      if (NUM_ENTRIES > TABLE_LEN) begin : g_bad_len
         $error("snum_pool: NUM_ENTRIES exceeds the serial table");
      end
      if (VAL_W < SER_W) begin : g_bad_w
         $error("snum_pool: VAL_W too narrow for serial values");
      end
   endgenerate

   logic [CNT_W-1:0]       size_q;
   logic [NUM_ENTRIES-1:0] active;
   logic [NUM_ENTRIES-1:0] used_q;
   logic [NUM_ENTRIES-1:0] used_n;
   logic [NUM_ENTRIES-1:0] rel_hit;
   logic [NUM_ENTRIES-1:0] free_now;
   logic [NUM_ENTRIES-1:0] free_pick;
   logic [NUM_ENTRIES-1:0] grant;
   logic                   found;
   logic [VAL_W-1:0]       pick_val;

   snum_size_sel #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .MIN_ENTRIES (MIN_ENTRIES),
      .DEF_ENTRIES (DEF_ENTRIES)
   ) u_size (
      .clk      (clk),
      .rst      (rst),
      .cfg_size (cfg_size),
      .size_q   (size_q),
      .active   (active)
   );

   snum_rel_match #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .VAL_W       (VAL_W)
   ) u_match (
      .rel_req (rel_req),
      .rel_val (rel_val),
      .active  (active),
      .hit     (rel_hit)
   );

   // Release takes effect before the allocation scan
   assign free_now  = ~used_q & active;
   assign free_pick = free_now | rel_hit;

   snum_pick #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .VAL_W       (VAL_W)
   ) u_pick (
      .free_vec (free_pick),
      .found    (found),
      .grant    (grant),
      .value    (pick_val)
   );

   snum_popcount #(
      .N (NUM_ENTRIES)
   ) u_cnt (
      .vec (free_now),
      .cnt (free_cnt)
   );

   always_comb begin
      used_n = used_q & ~rel_hit;
      if (alloc_req)
         used_n = used_n | grant;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         used_q     <= '0;
         resp_valid <= 1'b0;
         resp_fail  <= 1'b0;
         resp_val   <= '0;
      end else begin
         used_q     <= used_n;
         resp_valid <= alloc_req && found;
         resp_fail  <= alloc_req && !found;
         resp_val   <= (alloc_req && found) ? pick_val : '0;
      end
   end

   // R4
   alloc_ok_chk: assert property (@(posedge clk) disable iff (rst)
      (alloc_req && !rel_req && free_cnt != '0) |=>
         (resp_valid && !resp_fail && free_cnt == $past(free_cnt) - 1'b1));

   // R5
   alloc_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (alloc_req && !rel_req && free_cnt == '0) |=>
         (resp_fail && !resp_valid && resp_val == '0 && free_cnt == '0));

   // R7
   idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!alloc_req && !rel_req) |=> $stable(free_cnt));

   // R11
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      free_cnt <= size_q);

   // R6
   rel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rel_hit));

   // R4
   resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(resp_valid && resp_fail));

endmodule

// File: tb/snum_pool_tb.sv
module snum_pool_tb;

   localparam int N = 46;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] cfg_size = 6'd28;
   logic       alloc_req = 1'b0;
   logic       rel_req = 1'b0;
   logic [7:0] rel_val = 8'h00;
   logic       resp_valid;
   logic       resp_fail;
   logic [7:0] resp_val;
   logic [5:0] free_cnt;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   bit used_m [N];
   int size_m = 28;

   always #10 clk = ~clk;

   snum_pool u_dut (
      .clk        (clk),
      .rst        (rst),
      .cfg_size   (cfg_size),
      .alloc_req  (alloc_req),
      .rel_req    (rel_req),
      .rel_val    (rel_val),
      .resp_valid (resp_valid),
      .resp_fail  (resp_fail),
      .resp_val   (resp_val),
      .free_cnt   (free_cnt)
   );

   function automatic logic [7:0] ser(input int i);
      int b;
      if (i < 14)      b = 'h04 + 8 * (i / 2);
      else if (i < 28) b = 'h88 + 16 * ((i - 14) / 2);
      else if (i < 44) b = 'h08 + 16 * ((i - 28) / 2);
      else             b = 'h80;
      return 8'(b + (i % 2));
   endfunction

   function automatic int model_free();
      int c = 0;
      for (int i = 0; i < size_m; i++) if (!used_m[i]) c++;
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Reset with a size setting; R1 and R2 checked right after
   task automatic do_reset(input logic [5:0] cfg, input int exp_size, input string req);
      rst = 1'b1;
      cfg_size = cfg;
      alloc_req = 1'b0;
      rel_req = 1'b0;
      repeat (2) @(posedge clk);
      #5;
      rst = 1'b0;
      cfg_size = 6'd0;
      size_m = exp_size;
      for (int i = 0; i < N; i++) used_m[i] = 1'b0;
      chk(free_cnt == 6'(exp_size), req, free_cnt, exp_size);
      chk(!resp_valid && !resp_fail, "R1", {resp_valid, resp_fail}, 0);
   endtask

   // One cycle of stimulus, then compare with the model
   task automatic op(input bit a, input bit r, input logic [7:0] v, input string req);
      bit   exp_ok = 1'b0;
      logic [7:0] exp_v = 8'h00;
      if (r)
         for (int i = 0; i < size_m; i++) if (ser(i) == v) used_m[i] = 1'b0;
      if (a)
         for (int i = 0; i < size_m; i++)
            if (!used_m[i] && !exp_ok) begin
               used_m[i] = 1'b1;
               exp_ok = 1'b1;
               exp_v = ser(i);
            end
      alloc_req = a;
      rel_req = r;
      rel_val = v;
      @(posedge clk);
      #5;
      alloc_req = 1'b0;
      rel_req = 1'b0;
      chk(resp_valid == (a && exp_ok), req, resp_valid, a && exp_ok);
      chk(resp_fail == (a && !exp_ok), req, resp_fail, a && !exp_ok);
      if (a) chk(resp_val == exp_v, req, resp_val, exp_v);
      chk(free_cnt == 6'(model_free()), req, free_cnt, model_free());
   endtask

   task automatic t_sizes();
      do_reset(6'd28, 28, "R2");
      do_reset(6'd0, 28, "R2");
      do_reset(6'd27, 28, "R2");
      do_reset(6'd47, 28, "R2");
      do_reset(6'd63, 28, "R2");
      do_reset(6'd33, 33, "R2");
      do_reset(6'd46, 46, "R2");
   endtask

   task automatic t_drain_28();
      do_reset(6'd28, 28, "R1");
      for (int i = 0; i < 28; i++) op(1'b1, 1'b0, 8'h00, "R3");
      op(1'b1, 1'b0, 8'h00, "R10");
      op(1'b1, 1'b0, 8'h00, "R5");
   endtask

   task automatic t_release();
      op(1'b0, 1'b1, 8'h0C, "R6");
      op(1'b0, 1'b1, 8'h08, "R7");
      op(1'b0, 1'b1, 8'h07, "R7");
      op(1'b0, 1'b1, 8'h81, "R7");
      op(1'b0, 1'b1, 8'h0C, "R8");
      op(1'b0, 1'b1, 8'hE9, "R6");
      op(1'b1, 1'b0, 8'h00, "R4");
      op(1'b1, 1'b0, 8'h00, "R4");
      op(1'b1, 1'b0, 8'h00, "R5");
   endtask

   task automatic t_same_cycle();
      op(1'b1, 1'b1, 8'h89, "R9");
      op(1'b0, 1'b1, 8'hD9, "R6");
      op(1'b1, 1'b1, 8'h05, "R9");
      op(1'b1, 1'b0, 8'h00, "R11");
      op(1'b1, 1'b0, 8'h00, "R5");
   endtask

   task automatic t_drain_46();
      do_reset(6'd46, 46, "R1");
      for (int i = 0; i < 46; i++) op(1'b1, 1'b0, 8'h00, "R3");
      op(1'b1, 1'b0, 8'h00, "R10");
      op(1'b0, 1'b1, 8'h80, "R6");
      op(1'b0, 1'b1, 8'h0D, "R6");
      op(1'b1, 1'b0, 8'h00, "R4");
      op(1'b1, 1'b0, 8'h00, "R4");
      op(1'b0, 1'b1, 8'h3A, "R7");
   endtask

   initial begin
      t_sizes();
      t_drain_28();
      t_release();
      t_same_cycle();
      t_drain_46();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule